// File: doc/BRIEF.md
# Quadrature Phase-Rotating Programmable Clock Divider

This block divides a fast input clock by an integer ratio between 220 and 224 for use in the feedback path of a frequency synthesizer. A two-bit Johnson counter stepping on every input edge provides four quadrature phases of one quarter the input rate, with rising edges one input cycle apart. A multiplexer picks one of these phases and a fixed chain (one divide-by-two stage, then three divide-by-three stages, 54 in all) divides the picked phase down to the output clock.

The fractional part of the ratio comes from moving the multiplexer select forward by one quadrant, to the next lagging phase. Each such move lengthens one quarter-rate period from 4 to 5 input cycles. A decoder turns the requested ratio into a move count K (4 to 8). A pulse generator then asks for exactly K moves in every output period, so the period is 4·54 + K input cycles. A retimer applies each move only in a cycle where the old and the new phase are both high. No shortened or doubled pulse can reach the divide-by-54 chain. Everything runs on the input clock, and every path from the phase select to the multiplexer output goes through the same number of registers.

Top module: `qphase_divider`

## Requirements
- R1: With a ratio code of 220 to 224 applied, each output period is exactly that many input-clock cycles.
- R2: A code below 220 acts as 220 and a code above 224 acts as 224; the code is an unsigned 8-bit number.
- R3: Each output period is high for 72 + K input cycles and low for 144 input cycles, where K is the effective code minus 216, so no runt pulse appears.
- R4: The quarter-rate select advances only by one quadrant, one step per quarter-rate period, and only while both the old and the new phase are high. The selected phase therefore stays high at least 2 and low at least 2 input cycles, and every quarter-rate period is 4 or 5 cycles.
- R5: The ratio code is sampled only at an output rising edge and governs the period that begins at that edge. Code changes between two rising edges have no effect.
- R6: While reset is asserted the output is low. After release, the first output rising edge arrives within 240 input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fin | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 8 | Requested division ratio, unsigned |
| clk_o | output | 1 | Divided output clock |

## Verification
Every result of this block is a duration, measured from one output rising edge to the next, so the checks count input cycles between output transitions instead of sampling at a fixed delay. A code is due in the period that starts at the first output rising edge after it is applied. The bench therefore changes the code just after an observed rising edge, lets one period go by unmeasured, and measures the next one. It checks the high and low parts of that period separately. For the sampling rule, the code is changed and restored within a single period, and the length of that period must not move.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  localparam int unsigned RATIO_W   = 8;
  localparam int unsigned NUM_DIV3  = 3;
  localparam int unsigned K_MIN     = 4;
  localparam int unsigned K_MAX     = 8;
  localparam int unsigned N_CHAIN   = 2 * (3 ** NUM_DIV3);
  localparam int unsigned BASE_DIV  = 4 * N_CHAIN;
endpackage

// File: rtl/qphase_sel.sv
module qphase_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_req_i,
  output logic tick_o
);
  logic [1:0] john;
  logic [3:0] ph;
  logic [1:0] sel;
  logic       mux_r;
  logic       mux_d;
  logic       both_hi;
  logic       adv;

  // quadrature phases decoded from the Johnson state 00,01,11,10
  assign ph      = {~john[0], john[1], john[0], ~john[1]};
  // retimer: a move is allowed only while old and next phase are high
  assign both_hi = ph[sel] & ph[sel + 2'd1];
  assign adv     = adv_req_i & both_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      john  <= 2'b00;
      sel   <= 2'd0;
      mux_r <= 1'b0;
      mux_d <= 1'b0;
    end else begin
      john  <= {john[0], ~john[1]};
      if (adv) sel <= sel + 2'd1;
      mux_r <= ph[sel];
      mux_d <= mux_r;
    end
  end

  assign tick_o = mux_r & ~mux_d;

  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> (sel == $past(sel) + 2'd1)); // R4
  AST_MUX_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mux_r) |-> $past(mux_r, 2)); // R4
  AST_MUX_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_r) |-> !$past(mux_r, 2)); // R4
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    adv_req_i |-> tick_o); // R4
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import qdiv_pkg::*;
#(
  parameter int unsigned RW   = RATIO_W,
  parameter int unsigned KLO  = K_MIN,
  parameter int unsigned KHI  = K_MAX,
  parameter int unsigned BASE = BASE_DIV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_i,
  input  logic          tick_i,
  input  logic          wrap_i,
  output logic          adv_req_o
);
  localparam int unsigned KW = $clog2(KHI + 1);
  localparam logic [RW-1:0] LO_CODE = RW'(BASE + KLO);
  localparam logic [RW-1:0] HI_CODE = RW'(BASE + KHI);
  localparam logic [KW-1:0] KLO_V   = KW'(KLO);
  localparam logic [KW-1:0] KHI_V   = KW'(KHI);

  logic [KW-1:0] k_dec;
  logic [KW-1:0] k_cur;
  logic [KW-1:0] sw_cnt;

  // decoder: requested ratio -> moves per output period, clamped
  always_comb begin
    if (ratio_i < LO_CODE)      k_dec = KLO_V;
    else if (ratio_i > HI_CODE) k_dec = KHI_V;
    else                        k_dec = KW'(ratio_i - LO_CODE) + KLO_V;
  end

  // pulse generator: one move request on each of the first K ticks
  assign adv_req_o = tick_i & (wrap_i | (sw_cnt < k_cur));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_cur  <= KLO_V;
      sw_cnt <= '0;
    end else if (wrap_i) begin
      k_cur  <= k_dec;
      sw_cnt <= KW'(1);
    end else if (adv_req_o) begin
      sw_cnt <= sw_cnt + KW'(1);
    end
  end

  AST_K_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (k_cur >= KLO_V) && (k_cur <= KHI_V)); // R2
  AST_SW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cnt <= k_cur); // R1
endmodule

// File: rtl/chain_div.sv
module chain_div
  import qdiv_pkg::*;
#(
  parameter int unsigned STAGES3 = NUM_DIV3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic wrap_o,
  output logic clk_o
);
  logic half;
  logic en [STAGES3+1];
  logic top_zero;

  assign en[0] = tick_i & half;

  genvar g;
  generate
    for (g = 0; g < STAGES3; g++) begin : g_div3
      logic [1:0] cnt;
      // AND gate folded into the stage input: advance only when enabled
      assign en[g+1] = en[g] & (cnt == 2'd2);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= 2'd0;
        else if (en[g]) cnt <= (cnt == 2'd2) ? 2'd0 : cnt + 2'd1;
      end
      AST_DIV3_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3); // R3
    end
  endgenerate

  assign top_zero = (g_div3[STAGES3-1].cnt == 2'd0);
  assign wrap_o   = en[STAGES3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half  <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      if (tick_i) half <= ~half;
      if (wrap_o) clk_o <= 1'b1;
      else if (en[STAGES3-1] && top_zero) clk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qphase_divider.sv
module qphase_divider
  import qdiv_pkg::*;
#(
  parameter int unsigned RW      = RATIO_W,
  parameter int unsigned STAGES3 = NUM_DIV3,
  parameter int unsigned KLO     = K_MIN,
  parameter int unsigned KHI     = K_MAX
) (
  input  logic          clk_fin,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_i,
  output logic          clk_o
);
  localparam int unsigned BASE = 8 * (3 ** STAGES3);

  logic tick;
  logic wrap;
  logic adv_req;

  qphase_sel u_sel (
    .clk       (clk_fin),
    .rst_n     (rst_n),
    .adv_req_i (adv_req),
    .tick_o    (tick)
  );

  swallow_ctrl #(
    .RW   (RW),
    .KLO  (KLO),
    .KHI  (KHI),
    .BASE (BASE)
  ) u_ctrl (
    .clk       (clk_fin),
    .rst_n     (rst_n),
    .ratio_i   (ratio_i),
    .tick_i    (tick),
    .wrap_i    (wrap),
    .adv_req_o (adv_req)
  );

  chain_div #(
    .STAGES3 (STAGES3)
  ) u_chain (
    .clk    (clk_fin),
    .rst_n  (rst_n),
    .tick_i (tick),
    .wrap_o (wrap),
    .clk_o  (clk_o)
  );
endmodule

// File: tb/tb_qphase_divider.sv
module tb_qphase_divider;
  localparam time TCK = 4ns;
  localparam int NV = 9;
  // {code, expected period}
  localparam logic [15:0] VEC [NV] = '{
    {8'd220, 8'd220}, {8'd222, 8'd222}, {8'd224, 8'd224},
    {8'd221, 8'd221}, {8'd223, 8'd223}, {8'd0,   8'd220},
    {8'd219, 8'd220}, {8'd225, 8'd224}, {8'd255, 8'd224}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ratio = 8'd220;
  logic       clk_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  qphase_divider dut (.clk_fin(clk), .rst_n(rst_n), .ratio_i(ratio), .clk_o(clk_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges to the next output rise; hi = high samples in that span
  task automatic next_rise(output int per, output int hi);
    logic prev;
    prev = clk_o;
    per  = 0;
    hi   = clk_o ? 1 : 0;
    forever begin
      @(negedge clk);
      per++;
      if (!prev && clk_o) break;
      if (clk_o) hi++;
      prev = clk_o;
      if (per > 2000) begin
        n_chk++; n_fail++;
        $display("FAIL timeout actual=%0d expected=rise", per);
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p, h, d;
    repeat (5) @(negedge clk);
    check("R6 out low in reset", int'(clk_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    next_rise(p, h);
    check("R6 first rise bound", int'(p <= 240), 1);

    // table walk: code set right after a rise, period after next rise measured
    for (int i = 0; i < NV; i++) begin
      ratio = VEC[i][15:8];
      d = int'(VEC[i][7:0]);
      next_rise(p, h);
      next_rise(p, h);
      check($sformatf("R1 R2 period code=%0d", VEC[i][15:8]), p, d);
      check("R3 R4 high time", h, 72 + d - 216);
      check("R3 low time", p - h, 144);
    end

    // R5: code change and restore inside one period is ignored
    ratio = 8'd220;
    next_rise(p, h);
    next_rise(p, h);
    repeat (40) @(negedge clk);
    ratio = 8'd224;
    repeat (40) @(negedge clk);
    ratio = 8'd220;
    next_rise(p, h);
    check("R5 mid-period change ignored", p + 80, 220);
    next_rise(p, h);
    check("R5 following period", p, 220);

    // R6: reset in the middle of operation
    ratio = 8'd223;
    next_rise(p, h);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 out low after mid reset", int'(clk_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    next_rise(p, h);
    check("R6 first rise after mid reset", int'(p <= 240), 1);
    next_rise(p, h);
    check("R1 period after reset", p, 223);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule